// File: doc/BRIEF.md
# Beat-Serial Vector Load/MAC Engine

This block is a small vector engine with eight 128-bit vector registers and a 32-bit datapath. Every 128-bit instruction runs as four 32-bit beats, lowest beat first. There are two instructions. A vector load fills a register from a 32-bit memory read port. A vector multiply-accumulate works on signed 8-, 16- or 32-bit lanes. The load unit and the MAC unit are separate hardware, so a load that is still fetching and a MAC that is computing can each advance one beat in the same cycle.

Instructions arrive on one valid/ready issue channel. An instruction transfers on a rising edge where both `iss_valid` and `iss_ready` are high. `iss_ready` depends on the opcode and registers presented in that cycle. The source may hold its instruction for as long as it likes, and the engine never drops a presented instruction. The memory port is synchronous: the word for an address raised with `mem_rd_en` must appear on `mem_rd_data` in the cycle after. A combinational read-back port exposes any vector register.

Top module: `vbeat_engine`

## Requirements
- R1: After reset, every vector register reads back as zero, `mem_rd_en` and `esize_err` are low, and `iss_ready` is high for a load.
- R2: An accepted load raises `mem_rd_en` for four consecutive cycles, starting in the cycle after acceptance. The addresses are base, base+4, base+8 and base+12 for beats A to D.
- R3: The word returned one cycle after a beat's address is written into that beat of the destination, at bits [32k+31:32k] for beat k (A = 0). Beat A is visible on read-back two cycles after acceptance, while the higher beats still hold their old contents.
- R4: A MAC with size code 00 treats each register as sixteen signed 8-bit lanes and computes d = d + a*b in every lane, wrapping to 8 bits. Any of the three operands may name the same register.
- R5: Size code 01 gives eight signed 16-bit lanes with d = d + a*b, wrapping to 16 bits.
- R6: Size code 10 gives four signed 32-bit lanes with d = d + a*b, wrapping to 32 bits.
- R7: A MAC with size code 11 is accepted at once, pulses `esize_err` for exactly the cycle after acceptance, and changes no register.
- R8: A second instruction of the same kind is held off until its unit is retiring beat D of the previous one. For a MAC this means 3 stall cycles. For a load it means 4 stall cycles, because the last data beat lands one cycle after the last address.
- R9: A MAC whose registers are not the destination of an in-flight load is accepted in the cycle after that load, with no stall, and runs in the same cycles as the remaining load beats.
- R10: A MAC that reads or writes the destination of an in-flight load is stalled while that load's beat A is still unwritten. This costs exactly one cycle right after the load is accepted. The MAC then computes with the newly loaded data.
- R11: While `iss_valid` is low, nothing is started and no register changes, whatever the other issue fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue channel: instruction presented |
| iss_ready | output | 1 | Issue channel: instruction can be taken this cycle |
| iss_op | input | 1 | 0 = vector load, 1 = vector MAC |
| iss_vd | input | 3 | Destination register |
| iss_va | input | 3 | MAC first source register |
| iss_vb | input | 3 | MAC second source register |
| iss_esize | input | 2 | MAC lane size: 00 = 8, 01 = 16, 10 = 32, 11 reserved |
| iss_addr | input | 32 | Load base byte address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_data | input | 32 | Read word, valid one cycle after the strobe |
| esize_err | output | 1 | One-cycle pulse for a reserved lane size |
| rb_sel | input | 3 | Read-back register select |
| rb_data | output | 128 | Read-back register contents |

## Verification
A load's memory fetch and a MAC's beat computation can fall in the same cycle. When the MAC depends on the load, the register file must deliver each beat before the MAC reads it. The bench provokes both cases by presenting a MAC right after a load is accepted: once with unrelated registers, where it expects zero stall cycles and sees `mem_rd_en` still high after the MAC is taken, and once with the load's destination as a source or as the accumulator, where it expects exactly one stall cycle. In each case it judges the final register contents against a sequential model that applies the instructions in issue order.

// File: rtl/vbeat_pkg.sv
package vbeat_pkg;

  typedef enum logic {
    VOP_LOAD = 1'b0,
    VOP_MAC  = 1'b1
  } vop_e;

  // lane size code carried with a MAC
  typedef enum logic [1:0] {
    ESZ_8    = 2'b00,
    ESZ_16   = 2'b01,
    ESZ_32   = 2'b10,
    ESZ_RSVD = 2'b11
  } esize_e;

endpackage

// File: rtl/vbeat_regfile.sv
module vbeat_regfile #(
  parameter  int NUM_VREGS = 8,
  parameter  int NUM_BEATS = 4,
  parameter  int BEAT_W    = 32,
  localparam int RIDX_W    = $clog2(NUM_VREGS),
  localparam int BIDX_W    = $clog2(NUM_BEATS),
  localparam int VREG_W    = NUM_BEATS * BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // load write port
  input  logic              ld_we,
  input  logic [RIDX_W-1:0] ld_reg,
  input  logic [BIDX_W-1:0] ld_beat,
  input  logic [BEAT_W-1:0] ld_data,
  // MAC write port
  input  logic              mac_we,
  input  logic [RIDX_W-1:0] mac_reg,
  input  logic [BIDX_W-1:0] mac_beat,
  input  logic [BEAT_W-1:0] mac_data,
  // MAC operand reads, all on one beat
  input  logic [BIDX_W-1:0] rd_beat,
  input  logic [RIDX_W-1:0] rd_a_reg,
  input  logic [RIDX_W-1:0] rd_b_reg,
  input  logic [RIDX_W-1:0] rd_d_reg,
  output logic [BEAT_W-1:0] rd_a,
  output logic [BEAT_W-1:0] rd_b,
  output logic [BEAT_W-1:0] rd_d,
  // full-width read-back
  input  logic [RIDX_W-1:0] rb_sel,
  output logic [VREG_W-1:0] rb_data
);

  logic [BEAT_W-1:0] words [NUM_VREGS][NUM_BEATS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_VREGS; r++) begin
        for (int b = 0; b < NUM_BEATS; b++) begin
          words[r][b] <= '0;
        end
      end
    end else begin
      if (mac_we) words[mac_reg][mac_beat] <= mac_data;
      if (ld_we)  words[ld_reg][ld_beat]   <= ld_data;
    end
  end

  assign rd_a = words[rd_a_reg][rd_beat];
  assign rd_b = words[rd_b_reg][rd_beat];
  assign rd_d = words[rd_d_reg][rd_beat];

  always_comb begin
    for (int b = 0; b < NUM_BEATS; b++) begin
      rb_data[b*BEAT_W +: BEAT_W] = words[rb_sel][b];
    end
  end

  // the two write ports never aim at the same word in one cycle
  AST_ONE_WRITER_PER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_we && mac_we && ld_reg == mac_reg && ld_beat == mac_beat)); // R9

endmodule

// File: rtl/vbeat_load_unit.sv
module vbeat_load_unit #(
  parameter  int NUM_VREGS = 8,
  parameter  int NUM_BEATS = 4,
  parameter  int BEAT_W    = 32,
  parameter  int ADDR_W    = 32,
  localparam int RIDX_W    = $clog2(NUM_VREGS),
  localparam int BIDX_W    = $clog2(NUM_BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RIDX_W-1:0] start_reg,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              can_accept,
  // memory side
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [BEAT_W-1:0] mem_rd_data,
  // register-file write side
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_reg,
  output logic [BIDX_W-1:0] wr_beat,
  output logic [BEAT_W-1:0] wr_data,
  // hazard view
  output logic              pend,
  output logic [RIDX_W-1:0] pend_reg,
  output logic              first_fetch
);

  localparam int                BYTES_PER_BEAT = BEAT_W / 8;
  localparam logic [BIDX_W-1:0] LAST_BEAT      = BIDX_W'(NUM_BEATS - 1);

  // fetch stage: drives one address per cycle
  logic              f_busy;
  logic [BIDX_W-1:0] f_beat;
  logic [ADDR_W-1:0] f_addr;
  logic [RIDX_W-1:0] f_reg;
  // writeback stage: data returns one cycle after its address
  logic              w_valid;
  logic [BIDX_W-1:0] w_beat;
  logic [RIDX_W-1:0] w_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_busy <= 1'b0;
      f_beat <= '0;
      f_addr <= '0;
      f_reg  <= '0;
    end else if (start) begin
      f_busy <= 1'b1;
      f_beat <= '0;
      f_addr <= start_addr;
      f_reg  <= start_reg;
    end else if (f_busy) begin
      f_addr <= f_addr + ADDR_W'(BYTES_PER_BEAT);
      f_beat <= f_beat + 1'b1;
      if (f_beat == LAST_BEAT) f_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_valid <= 1'b0;
      w_beat  <= '0;
      w_reg   <= '0;
    end else begin
      w_valid <= f_busy;
      w_beat  <= f_beat;
      w_reg   <= f_reg;
    end
  end

  assign mem_rd_en   = f_busy;
  assign mem_rd_addr = f_addr;

  assign wr_en   = w_valid;
  assign wr_reg  = w_reg;
  assign wr_beat = w_beat;
  assign wr_data = mem_rd_data;

  // next load only once beat D is being retired (or unit empty)
  assign can_accept  = !f_busy && (!w_valid || w_beat == LAST_BEAT);
  assign pend        = f_busy || w_valid;
  assign pend_reg    = f_busy ? f_reg : w_reg;
  assign first_fetch = f_busy && (f_beat == '0);

  AST_LOAD_ADDR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (f_busy && f_beat != '0) |-> (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(BYTES_PER_BEAT))); // R2

  AST_LOAD_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !f_busy); // R8

endmodule

// File: rtl/vbeat_lane_mac.sv
module vbeat_lane_mac #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] src_a,
  input  logic [LANE_W-1:0] src_b,
  input  logic [LANE_W-1:0] acc_in,
  output logic [LANE_W-1:0] acc_out
);

  // The low LANE_W bits of a product are the same for signed and
  // unsigned operands, so the wrapped signed result needs no extension.
  assign acc_out = acc_in + src_a * src_b;

endmodule

// File: rtl/vbeat_beat_alu.sv
module vbeat_beat_alu
  import vbeat_pkg::*;
#(
  parameter int BEAT_W = 32
) (
  input  logic [BEAT_W-1:0] opa,
  input  logic [BEAT_W-1:0] opb,
  input  logic [BEAT_W-1:0] opd,
  input  logic [1:0]        esize,
  output logic [BEAT_W-1:0] res
);

  localparam int NUM_SIZES = 3;

  logic [NUM_SIZES-1:0][BEAT_W-1:0] res_by_size;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = 8 << s;
    localparam int NL = BEAT_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      vbeat_lane_mac #(.LANE_W(LW)) u_lane (
        .src_a  (opa[l*LW +: LW]),
        .src_b  (opb[l*LW +: LW]),
        .acc_in (opd[l*LW +: LW]),
        .acc_out(res_by_size[s][l*LW +: LW])
      );
    end
  end

  always_comb begin
    case (esize_e'(esize))
      ESZ_16:  res = res_by_size[1];
      ESZ_32:  res = res_by_size[2];
      default: res = res_by_size[0];
    endcase
  end

endmodule

// File: rtl/vbeat_mac_unit.sv
module vbeat_mac_unit
  import vbeat_pkg::*;
#(
  parameter  int NUM_VREGS = 8,
  parameter  int NUM_BEATS = 4,
  parameter  int BEAT_W    = 32,
  localparam int RIDX_W    = $clog2(NUM_VREGS),
  localparam int BIDX_W    = $clog2(NUM_BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RIDX_W-1:0] start_va,
  input  logic [RIDX_W-1:0] start_vb,
  input  logic [RIDX_W-1:0] start_vd,
  input  logic [1:0]        start_esize,
  output logic              can_accept,
  output logic              busy,
  output logic [BIDX_W-1:0] cur_beat,
  output logic [RIDX_W-1:0] rd_va,
  output logic [RIDX_W-1:0] rd_vb,
  output logic [RIDX_W-1:0] rd_vd,
  input  logic [BEAT_W-1:0] opa,
  input  logic [BEAT_W-1:0] opb,
  input  logic [BEAT_W-1:0] opd,
  output logic              wr_en,
  output logic [BEAT_W-1:0] wr_data
);

  localparam logic [BIDX_W-1:0] LAST_BEAT = BIDX_W'(NUM_BEATS - 1);

  logic [1:0] esize_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_beat <= '0;
      rd_va    <= '0;
      rd_vb    <= '0;
      rd_vd    <= '0;
      esize_q  <= ESZ_8;
    end else if (start) begin
      busy     <= 1'b1;
      cur_beat <= '0;
      rd_va    <= start_va;
      rd_vb    <= start_vb;
      rd_vd    <= start_vd;
      esize_q  <= start_esize;
    end else if (busy) begin
      cur_beat <= cur_beat + 1'b1;
      if (cur_beat == LAST_BEAT) busy <= 1'b0;
    end
  end

  vbeat_beat_alu #(.BEAT_W(BEAT_W)) u_alu (
    .opa  (opa),
    .opb  (opb),
    .opd  (opd),
    .esize(esize_q),
    .res  (wr_data)
  );

  assign wr_en      = busy;
  assign can_accept = !busy || (cur_beat == LAST_BEAT);

  AST_MAC_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!busy || cur_beat == LAST_BEAT)); // R8

  AST_MAC_NO_RESERVED_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (start_esize != ESZ_RSVD)); // R7

endmodule

// File: rtl/vbeat_engine.sv
module vbeat_engine
  import vbeat_pkg::*;
#(
  parameter  int NUM_VREGS = 8,
  parameter  int NUM_BEATS = 4,
  parameter  int BEAT_W    = 32,
  parameter  int ADDR_W    = 32,
  localparam int RIDX_W    = $clog2(NUM_VREGS),
  localparam int BIDX_W    = $clog2(NUM_BEATS),
  localparam int VREG_W    = NUM_BEATS * BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic              iss_op,
  input  logic [RIDX_W-1:0] iss_vd,
  input  logic [RIDX_W-1:0] iss_va,
  input  logic [RIDX_W-1:0] iss_vb,
  input  logic [1:0]        iss_esize,
  input  logic [ADDR_W-1:0] iss_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [BEAT_W-1:0] mem_rd_data,
  output logic              esize_err,
  input  logic [RIDX_W-1:0] rb_sel,
  output logic [VREG_W-1:0] rb_data
);

  localparam logic [BIDX_W-1:0] LAST_BEAT = BIDX_W'(NUM_BEATS - 1);

  // load unit wiring
  logic              ld_start, ld_can_accept;
  logic              ld_wr_en, ld_pend, ld_first_fetch;
  logic [RIDX_W-1:0] ld_wr_reg, ld_pend_reg;
  logic [BIDX_W-1:0] ld_wr_beat;
  logic [BEAT_W-1:0] ld_wr_data;

  // MAC unit wiring
  logic              mac_start, mac_can_accept, mac_busy, mac_wr_en;
  logic [BIDX_W-1:0] mac_beat;
  logic [RIDX_W-1:0] mac_va, mac_vb, mac_vd;
  logic [BEAT_W-1:0] mac_opa, mac_opb, mac_opd, mac_wr_data;

  // issue decode
  logic is_mac, is_rsvd, take, raw_block, ld_retiring;

  assign is_mac  = (vop_e'(iss_op) == VOP_MAC);
  assign is_rsvd = (esize_e'(iss_esize) == ESZ_RSVD);
  assign take    = iss_valid && iss_ready;

  // a MAC touching the load's destination waits until beat A has landed
  assign raw_block = ld_first_fetch &&
                     (ld_pend_reg == iss_va || ld_pend_reg == iss_vb || ld_pend_reg == iss_vd);

  always_comb begin
    if (!is_mac)      iss_ready = ld_can_accept;
    else if (is_rsvd) iss_ready = 1'b1;
    else              iss_ready = mac_can_accept && !raw_block;
  end

  assign ld_start  = take && !is_mac;
  assign mac_start = take && is_mac && !is_rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) esize_err <= 1'b0;
    else        esize_err <= take && is_mac && is_rsvd;
  end

  vbeat_load_unit #(
    .NUM_VREGS(NUM_VREGS), .NUM_BEATS(NUM_BEATS), .BEAT_W(BEAT_W), .ADDR_W(ADDR_W)
  ) u_load (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ld_start),
    .start_reg  (iss_vd),
    .start_addr (iss_addr),
    .can_accept (ld_can_accept),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data),
    .wr_en      (ld_wr_en),
    .wr_reg     (ld_wr_reg),
    .wr_beat    (ld_wr_beat),
    .wr_data    (ld_wr_data),
    .pend       (ld_pend),
    .pend_reg   (ld_pend_reg),
    .first_fetch(ld_first_fetch)
  );

  vbeat_mac_unit #(
    .NUM_VREGS(NUM_VREGS), .NUM_BEATS(NUM_BEATS), .BEAT_W(BEAT_W)
  ) u_mac (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (mac_start),
    .start_va   (iss_va),
    .start_vb   (iss_vb),
    .start_vd   (iss_vd),
    .start_esize(iss_esize),
    .can_accept (mac_can_accept),
    .busy       (mac_busy),
    .cur_beat   (mac_beat),
    .rd_va      (mac_va),
    .rd_vb      (mac_vb),
    .rd_vd      (mac_vd),
    .opa        (mac_opa),
    .opb        (mac_opb),
    .opd        (mac_opd),
    .wr_en      (mac_wr_en),
    .wr_data    (mac_wr_data)
  );

  vbeat_regfile #(
    .NUM_VREGS(NUM_VREGS), .NUM_BEATS(NUM_BEATS), .BEAT_W(BEAT_W)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_we   (ld_wr_en),
    .ld_reg  (ld_wr_reg),
    .ld_beat (ld_wr_beat),
    .ld_data (ld_wr_data),
    .mac_we  (mac_wr_en),
    .mac_reg (mac_vd),
    .mac_beat(mac_beat),
    .mac_data(mac_wr_data),
    .rd_beat (mac_beat),
    .rd_a_reg(mac_va),
    .rd_b_reg(mac_vb),
    .rd_d_reg(mac_vd),
    .rd_a    (mac_opa),
    .rd_b    (mac_opb),
    .rd_d    (mac_opd),
    .rb_sel  (rb_sel),
    .rb_data (rb_data)
  );

  // Tracks whether the running MAC was issued behind a load it depends on;
  // it only feeds the ordering check below.
  logic mac_dep_q;
  assign ld_retiring = ld_wr_en && (ld_wr_beat == LAST_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_dep_q <= 1'b0;
    end else if (mac_start) begin
      mac_dep_q <= ld_pend && !ld_retiring &&
                   (ld_pend_reg == iss_va || ld_pend_reg == iss_vb || ld_pend_reg == iss_vd);
    end else if (ld_retiring || (mac_busy && mac_beat == LAST_BEAT)) begin
      mac_dep_q <= 1'b0;
    end
  end

  AST_MAC_READS_LOADED_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_busy && mac_dep_q && ld_pend) |-> (ld_wr_en && ld_wr_beat > mac_beat)); // R10

  AST_ERR_ONLY_AFTER_MAC_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esize_err) |-> !mac_busy || $past(mac_busy)); // R7

endmodule

// File: tb/vbeat_engine_test.sv
module vbeat_engine_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         iss_valid = 1'b0;
  logic         iss_ready;
  logic         iss_op = 1'b0;
  logic [2:0]   iss_vd = '0, iss_va = '0, iss_vb = '0;
  logic [1:0]   iss_esize = '0;
  logic [31:0]  iss_addr = '0;
  logic         mem_rd_en;
  logic [31:0]  mem_rd_addr;
  logic [31:0]  mem_rd_data = '0;
  logic         esize_err;
  logic [2:0]   rb_sel = '0;
  logic [127:0] rb_data;

  int checks = 0;
  int fails  = 0;
  logic [127:0] exp_v [8];

  always #10 clk = ~clk; // 50 MHz

  vbeat_engine uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_vd(iss_vd), .iss_va(iss_va), .iss_vb(iss_vb),
    .iss_esize(iss_esize), .iss_addr(iss_addr), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .esize_err(esize_err),
    .rb_sel(rb_sel), .rb_data(rb_data)
  );

  function automatic logic [31:0] memword(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13579BDF;
  endfunction

  // synchronous memory: one cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= memword(mem_rd_addr);
  end

  function automatic logic [127:0] mac_model(input logic [127:0] a, b, d, input logic [1:0] es);
    logic [127:0] r;
    r = d;
    case (es)
      2'b00: for (int i = 0; i < 16; i++) begin
        logic signed [15:0] p;
        p = $signed(a[i*8 +: 8]) * $signed(b[i*8 +: 8]);
        r[i*8 +: 8] = d[i*8 +: 8] + p[7:0];
      end
      2'b01: for (int i = 0; i < 8; i++) begin
        logic signed [31:0] p;
        p = $signed(a[i*16 +: 16]) * $signed(b[i*16 +: 16]);
        r[i*16 +: 16] = d[i*16 +: 16] + p[15:0];
      end
      2'b10: for (int i = 0; i < 4; i++) begin
        logic signed [63:0] p;
        p = $signed(a[i*32 +: 32]) * $signed(b[i*32 +: 32]);
        r[i*32 +: 32] = d[i*32 +: 32] + p[31:0];
      end
      default: r = d;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // presents one instruction, counts stall cycles, updates the model
  task automatic do_issue(input logic op, input logic [2:0] vd, va, vb,
                          input logic [1:0] es, input logic [31:0] addr, output int stalls);
    stalls = 0;
    @(negedge clk);
    iss_valid = 1'b1; iss_op = op; iss_vd = vd; iss_va = va; iss_vb = vb;
    iss_esize = es; iss_addr = addr;
    #1;
    while (!iss_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    iss_valid = 1'b0;
    if (op == 1'b0)
      exp_v[vd] = {memword(addr + 32'd12), memword(addr + 32'd8), memword(addr + 32'd4), memword(addr)};
    else if (es != 2'b11)
      exp_v[vd] = mac_model(exp_v[va], exp_v[vb], exp_v[vd], es);
  endtask

  task automatic wait_idle();
    repeat (8) @(negedge clk);
  endtask

  task automatic chk_reg(input logic [2:0] r, input string tag);
    @(negedge clk);
    rb_sel = r;
    #1;
    chk(tag, rb_data, exp_v[r]);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ready for load after reset", 128'(iss_ready), 128'(1));
    chk("R1 no memory read after reset", 128'(mem_rd_en), 128'(0));
    chk("R1 no error after reset", 128'(esize_err), 128'(0));
    for (int r = 0; r < 8; r++) chk_reg(3'(r), "R1 register zero after reset");
  endtask

  task automatic t_load_sequence();
    int st;
    rb_sel = 3'd2;
    do_issue(1'b0, 3'd2, 3'd0, 3'd0, 2'b00, 32'h0000_0100, st);
    chk("R2 beat A strobe", 128'(mem_rd_en), 128'(1));
    chk("R2 beat A address", 128'(mem_rd_addr), 128'(32'h100));
    @(posedge clk); #1;
    chk("R2 beat B address", 128'(mem_rd_addr), 128'(32'h104));
    @(posedge clk); #1;
    chk("R2 beat C address", 128'(mem_rd_addr), 128'(32'h108));
    chk("R3 beat A landed, upper beats old", rb_data, {96'b0, memword(32'h100)});
    @(posedge clk); #1;
    chk("R2 beat D address", 128'(mem_rd_addr), 128'(32'h10C));
    @(posedge clk); #1;
    chk("R2 strobe drops after four beats", 128'(mem_rd_en), 128'(0));
    wait_idle();
    chk_reg(3'd2, "R3 full load contents");
  endtask

  task automatic t_mac_sizes();
    int st;
    do_issue(1'b0, 3'd0, 3'd0, 3'd0, 2'b00, 32'h0000_0200, st);
    do_issue(1'b0, 3'd1, 3'd0, 3'd0, 2'b00, 32'h0000_0300, st);
    do_issue(1'b0, 3'd3, 3'd0, 3'd0, 2'b00, 32'h0000_0400, st);
    do_issue(1'b0, 3'd4, 3'd0, 3'd0, 2'b00, 32'h0000_0500, st);
    do_issue(1'b0, 3'd5, 3'd0, 3'd0, 2'b00, 32'h0000_0600, st);
    do_issue(1'b0, 3'd6, 3'd0, 3'd0, 2'b00, 32'h0000_0680, st);
    wait_idle();
    do_issue(1'b1, 3'd3, 3'd0, 3'd1, 2'b00, 32'h0, st);
    wait_idle();
    chk_reg(3'd3, "R4 8-bit lanes");
    do_issue(1'b1, 3'd6, 3'd6, 3'd6, 2'b00, 32'h0, st);
    wait_idle();
    chk_reg(3'd6, "R4 8-bit lanes, all operands aliased");
    do_issue(1'b1, 3'd4, 3'd0, 3'd1, 2'b01, 32'h0, st);
    wait_idle();
    chk_reg(3'd4, "R5 16-bit lanes");
    do_issue(1'b1, 3'd5, 3'd1, 3'd3, 2'b10, 32'h0, st);
    wait_idle();
    chk_reg(3'd5, "R6 32-bit lanes");
  endtask

  task automatic t_reserved_size();
    int st;
    do_issue(1'b1, 3'd3, 3'd0, 3'd1, 2'b11, 32'h0, st);
    chk("R7 reserved size accepted at once", 128'(st), 128'(0));
    chk("R7 error pulse after acceptance", 128'(esize_err), 128'(1));
    @(posedge clk); #1;
    chk("R7 error pulse is one cycle", 128'(esize_err), 128'(0));
    wait_idle();
    chk_reg(3'd3, "R7 reserved size leaves register unchanged");
  endtask

  task automatic t_same_kind();
    int st;
    do_issue(1'b0, 3'd0, 3'd0, 3'd0, 2'b00, 32'h0000_1000, st);
    do_issue(1'b0, 3'd7, 3'd0, 3'd0, 2'b00, 32'h0000_2000, st);
    chk("R8 load behind load stall cycles", 128'(st), 128'(4));
    wait_idle();
    chk_reg(3'd0, "R8 first load result");
    chk_reg(3'd7, "R8 second load result");
    do_issue(1'b1, 3'd2, 3'd0, 3'd7, 2'b01, 32'h0, st);
    do_issue(1'b1, 3'd3, 3'd7, 3'd2, 2'b00, 32'h0, st);
    chk("R8 MAC behind MAC stall cycles", 128'(st), 128'(3));
    wait_idle();
    chk_reg(3'd3, "R8 chained MAC result");
  endtask

  task automatic t_overlap();
    int st;
    do_issue(1'b0, 3'd1, 3'd0, 3'd0, 2'b00, 32'h0000_0700, st);
    do_issue(1'b1, 3'd2, 3'd3, 3'd4, 2'b10, 32'h0, st);
    chk("R9 independent MAC not stalled", 128'(st), 128'(0));
    chk("R9 load still fetching while MAC runs", 128'(mem_rd_en), 128'(1));
    wait_idle();
    chk_reg(3'd1, "R9 overlapped load result");
    chk_reg(3'd2, "R9 overlapped MAC result");
  endtask

  task automatic t_raw();
    int st;
    do_issue(1'b0, 3'd5, 3'd0, 3'd0, 2'b00, 32'h0000_0800, st);
    do_issue(1'b1, 3'd6, 3'd5, 3'd0, 2'b00, 32'h0, st);
    chk("R10 source hazard stall cycles", 128'(st), 128'(1));
    wait_idle();
    chk_reg(3'd6, "R10 MAC used freshly loaded source");
    do_issue(1'b0, 3'd6, 3'd0, 3'd0, 2'b00, 32'h0000_0900, st);
    do_issue(1'b1, 3'd6, 3'd0, 3'd1, 2'b01, 32'h0, st);
    chk("R10 accumulator hazard stall cycles", 128'(st), 128'(1));
    wait_idle();
    chk_reg(3'd6, "R10 MAC accumulated onto loaded value");
  endtask

  task automatic t_idle_valid();
    int seen = 0;
    @(negedge clk);
    iss_valid = 1'b0; iss_op = 1'b0; iss_vd = 3'd7; iss_addr = 32'h0000_3000;
    repeat (6) begin
      @(negedge clk); #1;
      if (mem_rd_en) seen++;
    end
    chk("R11 no fetch while valid low", 128'(seen), 128'(0));
    iss_op = 1'b1; iss_va = 3'd0; iss_vb = 3'd1; iss_esize = 2'b00;
    wait_idle();
    chk_reg(3'd7, "R11 register unchanged while valid low");
  endtask

  initial begin
    for (int r = 0; r < 8; r++) exp_v[r] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_load_sequence();
    t_mac_sizes();
    t_reserved_size();
    t_same_kind();
    t_overlap();
    t_raw();
    t_idle_valid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule